// File: doc/BRIEF.md
# Privileged Special Register Access Unit

This unit serves the move-to and move-from special register instructions of a 32-bit core. Each cycle it can take one read strobe or one write strobe together with a 16-bit register address and, for writes, a 32-bit data word. It decides whether the access is allowed by checking the core's privilege bits, the address range and per-register read and write permissions. It then returns the read value one cycle later or applies the write.

The unit holds the status word, the exception return address, the saved exception status, the floating-point control word, the two halves of the multiply-accumulate result, and a 512-entry shadow copy of the general registers. Version, unit-present and configuration words are constants set by parameters. The previous-PC word comes from the core. Some writes have side effects. A write to the next-PC slot does not store anything: it redirects the fetch and clears the pending delay-slot state. A write to the tick-mode slot is accepted only when the value is zero. Refused or malformed accesses raise one-cycle error pulses, which the core can use to report them.

Top module: `spr_access_unit`

## Requirements
- R1: When `sup_mode_i` and `user_acc_i` are both 0, any access is refused. A refused read returns 0, a refused write changes nothing, and `priv_err_o` is 1 in the cycle after the strobe.
- R2: Any address at or above 0x0600 is invalid. A read returns 0, a write changes nothing, and `addr_err_o` is 1 in the cycle after the strobe. A write to 0x0600 does not alias shadow entry 0.
- R3: These addresses are readable: 0x0000 version, 0x0001 unit-present, 0x0002 config, 0x0010 status, 0x0012 previous-PC, 0x0014 FPU control, 0x0020 exception PC, 0x0040 MAC low, 0x0041 MAC high, and the shadow window. Reading any other address below 0x0600 returns 0 and raises `addr_err_o`. This includes the write-only slots 0x0011, 0x0030 and 0x0050.
- R4: These addresses are writable: 0x0010, 0x0014, 0x0020, 0x0030 exception status (shown on `esr_o`), 0x0040, 0x0041, the shadow window, and the side-effect slots 0x0011 and 0x0050. Writing any other address raises `addr_err_o` and changes nothing.
- R5: `rd_data_o` and `rd_valid_o` are registered and appear in the cycle after `rd_i`. When `rd_valid_o` is 0, `rd_data_o` is 0.
- R6: A write to the status word stores the data with bit 15 (the fixed-one bit) forced to 1. The status resets to 0x00008001 and is visible on `status_o`.
- R7: A write to 0x0011 gives a one-cycle pulse on `redirect_o` and `clr_dslot_o` in the next cycle, with `redirect_pc_o` equal to the written data. Nothing is stored.
- R8: A write of 0 to 0x0050 raises no flag. A nonzero write there raises `bad_val_o` but not `addr_err_o`.
- R9: The version, unit-present and config reads return the parameters `VER_VAL`, `UPR_VAL` and `CFG_VAL` (defaults 0x12000001, 0x00000619, 0x00000020). Writes to them are refused as in R4.
- R10: The shadow window covers 0x0400 to 0x05FF, mapping to entries 0 to 511. Each entry holds what was last written to it.
- R11: When `user_acc_i` is 1, access is granted even with `sup_mode_i` at 0.
- R12: A read of 0x0012 returns `prev_pc_i` as sampled in the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 16 | Register address |
| wdata_i | input | 32 | Write data |
| sup_mode_i | input | 1 | Supervisor mode bit |
| user_acc_i | input | 1 | User access grant bit |
| prev_pc_i | input | 32 | Previous-PC value from the core |
| rd_data_o | output | 32 | Registered read data |
| rd_valid_o | output | 1 | Read data valid |
| redirect_o | output | 1 | Fetch redirect pulse |
| redirect_pc_o | output | 32 | Redirect target |
| clr_dslot_o | output | 1 | Clear next-delay-slot pulse |
| priv_err_o | output | 1 | Privilege refusal pulse |
| addr_err_o | output | 1 | Invalid address or direction pulse |
| bad_val_o | output | 1 | Nonzero tick-mode write pulse |
| status_o | output | 32 | Current status word |
| esr_o | output | 32 | Saved exception status |

## Verification
A decode fault, such as a wrong permission list or a shadow window off by one, shows up on the first access to the affected address. It appears one cycle after the strobe, as a wrong `addr_err_o` pulse or wrong read data. Corrupted held state, such as a lost fixed-one bit or a write that was not dropped, stays hidden until the word is read back or shown on `status_o` or `esr_o`. For that reason every write scenario ends with a read-back in the following cycles. A faulty redirect path is seen on the very next cycle as a missing or extra pulse, or a wrong target.

// File: rtl/spr_pkg.sv
package spr_pkg;
  localparam int SPR_AW = 16;

  localparam logic [SPR_AW-1:0] A_VERSION = 16'h0000;
  localparam logic [SPR_AW-1:0] A_UNITS   = 16'h0001;
  localparam logic [SPR_AW-1:0] A_CONFIG  = 16'h0002;
  localparam logic [SPR_AW-1:0] A_STATUS  = 16'h0010;
  localparam logic [SPR_AW-1:0] A_NEXTPC  = 16'h0011;
  localparam logic [SPR_AW-1:0] A_PREVPC  = 16'h0012;
  localparam logic [SPR_AW-1:0] A_FPCTL   = 16'h0014;
  localparam logic [SPR_AW-1:0] A_EXCPC   = 16'h0020;
  localparam logic [SPR_AW-1:0] A_EXCSR   = 16'h0030;
  localparam logic [SPR_AW-1:0] A_MACLO   = 16'h0040;
  localparam logic [SPR_AW-1:0] A_MACHI   = 16'h0041;
  localparam logic [SPR_AW-1:0] A_TICKMD  = 16'h0050;

  typedef enum logic [3:0] {
    K_NONE, K_VERSION, K_UNITS, K_CONFIG, K_STATUS, K_NEXTPC, K_PREVPC,
    K_FPCTL, K_EXCPC, K_EXCSR, K_MACLO, K_MACHI, K_TICKMD, K_SHADOW
  } spr_kind_e;
endpackage

// File: rtl/spr_decode.sv
module spr_decode #(
  parameter int NUM_REGS  = 1536,
  parameter int GPR_BASE  = 1024,
  parameter int GPR_DEPTH = 512,
  localparam int GIDX_W   = $clog2(GPR_DEPTH)
) (
  input  logic [spr_pkg::SPR_AW-1:0] addr_i,
  output spr_pkg::spr_kind_e         kind_o,
  output logic                       rd_ok_o,
  output logic                       wr_ok_o,
  output logic [GIDX_W-1:0]          gidx_o
);
  import spr_pkg::*;

  localparam int GPR_END = GPR_BASE + GPR_DEPTH;

  always_comb begin
    kind_o = K_NONE;
    if (int'(addr_i) < NUM_REGS) begin
      if (int'(addr_i) >= GPR_BASE && int'(addr_i) < GPR_END) begin
        kind_o = K_SHADOW;
      end else begin
        case (addr_i)
          A_VERSION: kind_o = K_VERSION;
          A_UNITS:   kind_o = K_UNITS;
          A_CONFIG:  kind_o = K_CONFIG;
          A_STATUS:  kind_o = K_STATUS;
          A_NEXTPC:  kind_o = K_NEXTPC;
          A_PREVPC:  kind_o = K_PREVPC;
          A_FPCTL:   kind_o = K_FPCTL;
          A_EXCPC:   kind_o = K_EXCPC;
          A_EXCSR:   kind_o = K_EXCSR;
          A_MACLO:   kind_o = K_MACLO;
          A_MACHI:   kind_o = K_MACHI;
          A_TICKMD:  kind_o = K_TICKMD;
          default:   kind_o = K_NONE;
        endcase
      end
    end
  end

  always_comb begin
    case (kind_o)
      K_VERSION, K_UNITS, K_CONFIG, K_PREVPC: begin rd_ok_o = 1'b1; wr_ok_o = 1'b0; end
      K_STATUS, K_FPCTL, K_EXCPC, K_MACLO, K_MACHI, K_SHADOW: begin rd_ok_o = 1'b1; wr_ok_o = 1'b1; end
      K_NEXTPC, K_EXCSR, K_TICKMD: begin rd_ok_o = 1'b0; wr_ok_o = 1'b1; end
      default: begin rd_ok_o = 1'b0; wr_ok_o = 1'b0; end
    endcase
  end

  assign gidx_o = GIDX_W'(int'(addr_i) - GPR_BASE);
endmodule

// File: rtl/spr_shadow_bank.sv
module spr_shadow_bank #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 512,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem_q[idx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/spr_access_unit.sv
module spr_access_unit #(
  parameter int          DATA_W    = 32,
  parameter int          NUM_REGS  = 1536,
  parameter int          GPR_BASE  = 1024,
  parameter int          GPR_DEPTH = 512,
  parameter int          FO_BIT    = 15,
  parameter logic [31:0] SR_RESET  = 32'h0000_8001,
  parameter logic [31:0] VER_VAL   = 32'h1200_0001,
  parameter logic [31:0] UPR_VAL   = 32'h0000_0619,
  parameter logic [31:0] CFG_VAL   = 32'h0000_0020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [15:0]       addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              sup_mode_i,
  input  logic              user_acc_i,
  input  logic [DATA_W-1:0] prev_pc_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              redirect_o,
  output logic [DATA_W-1:0] redirect_pc_o,
  output logic              clr_dslot_o,
  output logic              priv_err_o,
  output logic              addr_err_o,
  output logic              bad_val_o,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] esr_o
);
  import spr_pkg::*;

  localparam int GIDX_W = $clog2(GPR_DEPTH);
  localparam logic [DATA_W-1:0] FO_MASK = DATA_W'(1) << FO_BIT;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  // decode
  spr_kind_e         kind;
  logic              rd_ok, wr_ok;
  logic [GIDX_W-1:0] gidx;

  spr_decode #(
    .NUM_REGS (NUM_REGS),
    .GPR_BASE (GPR_BASE),
    .GPR_DEPTH(GPR_DEPTH)
  ) u_decode (
    .addr_i (addr_i),
    .kind_o (kind),
    .rd_ok_o(rd_ok),
    .wr_ok_o(wr_ok),
    .gidx_o (gidx)
  );

  logic priv_ok, rd_go, wr_go;
  assign priv_ok = sup_mode_i | user_acc_i;
  assign rd_go   = rd_i & priv_ok & rd_ok;
  assign wr_go   = wr_i & priv_ok & wr_ok;

  // shadow register window
  logic [DATA_W-1:0] shadow_rdata;
  logic              shadow_we;
  assign shadow_we = wr_go & (kind == K_SHADOW);

  spr_shadow_bank #(
    .DATA_W(DATA_W),
    .DEPTH (GPR_DEPTH)
  ) u_shadow (
    .clk    (clk),
    .we_i   (shadow_we),
    .idx_i  (gidx),
    .wdata_i(wdata_i),
    .rdata_o(shadow_rdata)
  );

  // held registers
  logic [DATA_W-1:0] sr_q, sr_d, epc_q, epc_d, esr_q, esr_d;
  logic [DATA_W-1:0] fpc_q, fpc_d, mlo_q, mlo_d, mhi_q, mhi_d;
  logic              held_en;

  assign held_en = wr_go;

  always_comb begin
    sr_d  = sr_q;
    epc_d = epc_q;
    esr_d = esr_q;
    fpc_d = fpc_q;
    mlo_d = mlo_q;
    mhi_d = mhi_q;
    case (kind)
      K_STATUS: sr_d  = wdata_i | FO_MASK;
      K_EXCPC:  epc_d = wdata_i;
      K_EXCSR:  esr_d = wdata_i;
      K_FPCTL:  fpc_d = wdata_i;
      K_MACLO:  mlo_d = wdata_i;
      K_MACHI:  mhi_d = wdata_i;
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      sr_q  <= SR_RESET;
      epc_q <= '0;
      esr_q <= '0;
      fpc_q <= '0;
      mlo_q <= '0;
      mhi_q <= '0;
    end else if (held_en) begin
      sr_q  <= sr_d;
      epc_q <= epc_d;
      esr_q <= esr_d;
      fpc_q <= fpc_d;
      mlo_q <= mlo_d;
      mhi_q <= mhi_d;
    end
  end

  // read mux
  logic [DATA_W-1:0] rd_val, rd_data_d;
  always_comb begin
    case (kind)
      K_VERSION: rd_val = VER_VAL;
      K_UNITS:   rd_val = UPR_VAL;
      K_CONFIG:  rd_val = CFG_VAL;
      K_STATUS:  rd_val = sr_q;
      K_PREVPC:  rd_val = prev_pc_i;
      K_FPCTL:   rd_val = fpc_q;
      K_EXCPC:   rd_val = epc_q;
      K_MACLO:   rd_val = mlo_q;
      K_MACHI:   rd_val = mhi_q;
      K_SHADOW:  rd_val = shadow_rdata;
      default:   rd_val = '0;
    endcase
    rd_data_d = rd_go ? rd_val : '0;
  end

  // response and side-effect next state
  logic priv_err_d, addr_err_d, bad_val_d, redirect_d;
  always_comb begin
    priv_err_d = (rd_i | wr_i) & ~priv_ok;
    addr_err_d = priv_ok & ((rd_i & ~rd_ok) | (wr_i & ~wr_ok));
    bad_val_d  = wr_go & (kind == K_TICKMD) & (|wdata_i);
    redirect_d = wr_go & (kind == K_NEXTPC);
  end

  logic [DATA_W-1:0] rd_data_q, redir_pc_q;
  logic              rd_valid_q, priv_err_q, addr_err_q, bad_val_q, redirect_q;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
      priv_err_q <= 1'b0;
      addr_err_q <= 1'b0;
      bad_val_q  <= 1'b0;
      redirect_q <= 1'b0;
    end else begin
      rd_data_q  <= rd_data_d;
      rd_valid_q <= rd_i;
      priv_err_q <= priv_err_d;
      addr_err_q <= addr_err_d;
      bad_val_q  <= bad_val_d;
      redirect_q <= redirect_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)         redir_pc_q <= '0;
    else if (redirect_d) redir_pc_q <= wdata_i;
  end

  assign rd_data_o     = rd_data_q;
  assign rd_valid_o    = rd_valid_q;
  assign redirect_o    = redirect_q;
  assign redirect_pc_o = redir_pc_q;
  assign clr_dslot_o   = redirect_q;
  assign priv_err_o    = priv_err_q;
  assign addr_err_o    = addr_err_q;
  assign bad_val_o     = bad_val_q;
  assign status_o      = sr_q;
  assign esr_o         = esr_q;
endmodule

// File: rtl/spr_access_unit_chk.sv
module spr_access_unit_chk #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 1536,
  parameter int FO_BIT   = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_i,
  input logic              wr_i,
  input logic [15:0]       addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              sup_mode_i,
  input logic              user_acc_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rd_valid_o,
  input logic              redirect_o,
  input logic [DATA_W-1:0] redirect_pc_o,
  input logic              priv_err_o,
  input logic              addr_err_o,
  input logic              bad_val_o,
  input logic [DATA_W-1:0] status_o
);
  // R5
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid_o |-> rd_data_o == '0);

  // R1
  priv_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_i && !sup_mode_i && !user_acc_i) |-> (priv_err_o && rd_data_o == '0));

  // R7
  redirect_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (redirect_pc_o == $past(wdata_i) && !priv_err_o && !addr_err_o));

  // R6
  sr_fixed_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_i && (sup_mode_i || user_acc_i) && addr_i == 16'h0010) |-> status_o[FO_BIT]);

  // R8
  tick_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_i && !rd_i && (sup_mode_i || user_acc_i) && addr_i == 16'h0050 && wdata_i == '0)
      |-> (!bad_val_o && !addr_err_o));

  // R2
  high_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past((rd_i || wr_i) && (sup_mode_i || user_acc_i) && int'(addr_i) >= NUM_REGS)
      |-> (addr_err_o && rd_data_o == '0));
endmodule

bind spr_access_unit spr_access_unit_chk #(
  .DATA_W  (DATA_W),
  .NUM_REGS(NUM_REGS),
  .FO_BIT  (FO_BIT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sn),
  .rd_i         (rd_i),
  .wr_i         (wr_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .sup_mode_i   (sup_mode_i),
  .user_acc_i   (user_acc_i),
  .rd_data_o    (rd_data_o),
  .rd_valid_o   (rd_valid_o),
  .redirect_o   (redirect_o),
  .redirect_pc_o(redirect_pc_o),
  .priv_err_o   (priv_err_o),
  .addr_err_o   (addr_err_o),
  .bad_val_o    (bad_val_o),
  .status_o     (status_o)
);

// File: tb/spr_access_unit_test.sv
`timescale 1ns/1ps
module spr_access_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_i, wr_i, sup_mode_i, user_acc_i;
  logic [15:0] addr_i;
  logic [31:0] wdata_i, prev_pc_i;
  logic [31:0] rd_data_o, redirect_pc_o, status_o, esr_o;
  logic        rd_valid_o, redirect_o, clr_dslot_o, priv_err_o, addr_err_o, bad_val_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  spr_access_unit uut (
    .clk(clk), .rst_n(rst_n), .rd_i(rd_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .sup_mode_i(sup_mode_i), .user_acc_i(user_acc_i),
    .prev_pc_i(prev_pc_i), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
    .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o), .clr_dslot_o(clr_dslot_o),
    .priv_err_o(priv_err_o), .addr_err_o(addr_err_o), .bad_val_o(bad_val_o),
    .status_o(status_o), .esr_o(esr_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one strobe for one cycle; outputs for it are stable on return
  task automatic access(input bit r, input bit w, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    rd_i = r; wr_i = w; addr_i = a; wdata_i = d;
    @(negedge clk);
    rd_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic flags(input string tag, input bit pe, input bit ae, input bit bv);
    check({tag, " priv_err"}, {31'd0, priv_err_o}, {31'd0, pe});
    check({tag, " addr_err"}, {31'd0, addr_err_o}, {31'd0, ae});
    check({tag, " bad_val"},  {31'd0, bad_val_o},  {31'd0, bv});
  endtask

  task automatic t_reset();
    check("R6 reset status", status_o, 32'h0000_8001);
    check("R5 reset rd_valid", {31'd0, rd_valid_o}, 32'd0);
    check("R5 reset rd_data", rd_data_o, 32'd0);
    check("R7 reset redirect", {31'd0, redirect_o}, 32'd0);
    flags("R1 reset", 0, 0, 0);
  endtask

  task automatic t_consts();
    access(1, 0, 16'h0000, 0);
    check("R9 version", rd_data_o, 32'h1200_0001);
    check("R5 valid after read", {31'd0, rd_valid_o}, 32'd1);
    flags("R3 version", 0, 0, 0);
    access(1, 0, 16'h0001, 0);
    check("R9 unit-present", rd_data_o, 32'h0000_0619);
    access(1, 0, 16'h0002, 0);
    check("R9 config", rd_data_o, 32'h0000_0020);
    access(0, 1, 16'h0000, 32'hDEAD_0000);
    flags("R4 write version", 0, 1, 0);
    access(1, 0, 16'h0000, 0);
    check("R9 version unchanged", rd_data_o, 32'h1200_0001);
  endtask

  task automatic t_idle();
    access(1, 0, 16'h0001, 0);
    @(negedge clk);
    check("R5 idle valid", {31'd0, rd_valid_o}, 32'd0);
    check("R5 idle data", rd_data_o, 32'd0);
  endtask

  task automatic t_status();
    access(0, 1, 16'h0010, 32'h0000_0004);
    check("R6 status forced one", status_o, 32'h0000_8004);
    access(1, 0, 16'h0010, 0);
    check("R6 status readback", rd_data_o, 32'h0000_8004);
    access(0, 1, 16'h0010, 32'hFFFF_0001);
    check("R6 status all ones kept", status_o, 32'hFFFF_8001);
    access(0, 1, 16'h0010, 32'h0000_8001);
  endtask

  task automatic t_rw_regs();
    access(0, 1, 16'h0014, 32'h0000_0F0F);
    access(0, 1, 16'h0020, 32'h0000_2000);
    access(0, 1, 16'h0040, 32'h1111_2222);
    access(0, 1, 16'h0041, 32'h3333_4444);
    flags("R4 mac high write", 0, 0, 0);
    access(1, 0, 16'h0014, 0);
    check("R4 fpu ctl readback", rd_data_o, 32'h0000_0F0F);
    access(1, 0, 16'h0020, 0);
    check("R4 exc pc readback", rd_data_o, 32'h0000_2000);
    access(1, 0, 16'h0040, 0);
    check("R4 mac low readback", rd_data_o, 32'h1111_2222);
    access(1, 0, 16'h0041, 0);
    check("R4 mac high readback", rd_data_o, 32'h3333_4444);
    access(0, 1, 16'h0030, 32'h0000_ABCD);
    check("R4 exc status stored", esr_o, 32'h0000_ABCD);
    access(1, 0, 16'h0030, 0);
    check("R3 exc status not readable", rd_data_o, 32'd0);
    flags("R3 exc status read", 0, 1, 0);
  endtask

  task automatic t_npc();
    access(0, 1, 16'h0011, 32'h1234_5678);
    check("R7 redirect pulse", {31'd0, redirect_o}, 32'd1);
    check("R7 clear delay slot", {31'd0, clr_dslot_o}, 32'd1);
    check("R7 redirect target", redirect_pc_o, 32'h1234_5678);
    flags("R7 npc write", 0, 0, 0);
    @(negedge clk);
    check("R7 redirect single cycle", {31'd0, redirect_o}, 32'd0);
    access(1, 0, 16'h0011, 0);
    check("R7 npc not stored", rd_data_o, 32'd0);
    flags("R3 npc read", 0, 1, 0);
  endtask

  task automatic t_tick();
    access(0, 1, 16'h0050, 32'd0);
    flags("R8 tick zero", 0, 0, 0);
    access(0, 1, 16'h0050, 32'd5);
    flags("R8 tick nonzero", 0, 0, 1);
    access(1, 0, 16'h0050, 0);
    flags("R3 tick read", 0, 1, 0);
  endtask

  task automatic t_priv();
    sup_mode_i = 1'b0; user_acc_i = 1'b0;
    access(1, 0, 16'h0020, 0);
    check("R1 refused read data", rd_data_o, 32'd0);
    flags("R1 refused read", 1, 0, 0);
    access(0, 1, 16'h0020, 32'h0BAD_0BAD);
    flags("R1 refused write", 1, 0, 0);
    access(0, 1, 16'h0011, 32'h0000_4444);
    check("R1 refused npc no redirect", {31'd0, redirect_o}, 32'd0);
    sup_mode_i = 1'b1;
    access(1, 0, 16'h0020, 0);
    check("R1 write dropped", rd_data_o, 32'h0000_2000);
  endtask

  task automatic t_user();
    sup_mode_i = 1'b0; user_acc_i = 1'b1;
    access(0, 1, 16'h0014, 32'h0000_0077);
    flags("R11 user write", 0, 0, 0);
    access(1, 0, 16'h0014, 0);
    check("R11 user readback", rd_data_o, 32'h0000_0077);
    sup_mode_i = 1'b1; user_acc_i = 1'b0;
  endtask

  task automatic t_shadow_and_high();
    access(0, 1, 16'h0400, 32'hA000_0000);
    access(0, 1, 16'h05FF, 32'hA000_01FF);
    access(0, 1, 16'h04AB, 32'hA000_00AB);
    access(1, 0, 16'h0400, 0);
    check("R10 shadow first", rd_data_o, 32'hA000_0000);
    access(1, 0, 16'h05FF, 0);
    check("R10 shadow last", rd_data_o, 32'hA000_01FF);
    access(1, 0, 16'h04AB, 0);
    check("R10 shadow middle", rd_data_o, 32'hA000_00AB);
    access(0, 1, 16'h0600, 32'hBBBB_BBBB);
    flags("R2 write past end", 0, 1, 0);
    access(1, 0, 16'h0400, 0);
    check("R2 no alias to entry 0", rd_data_o, 32'hA000_0000);
    access(1, 0, 16'h0600, 0);
    check("R2 read past end", rd_data_o, 32'd0);
    flags("R2 read past end", 0, 1, 0);
    access(1, 0, 16'hFFFF, 0);
    flags("R2 top address", 0, 1, 0);
    access(1, 0, 16'h0123, 0);
    check("R3 unlisted read", rd_data_o, 32'd0);
    flags("R3 unlisted read", 0, 1, 0);
  endtask

  task automatic t_prevpc();
    prev_pc_i = 32'hCAFE_BABE;
    access(1, 0, 16'h0012, 0);
    check("R12 previous pc", rd_data_o, 32'hCAFE_BABE);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; rd_i = 1'b0; wr_i = 1'b0; addr_i = '0; wdata_i = '0;
    sup_mode_i = 1'b1; user_acc_i = 1'b0; prev_pc_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_consts();
    t_idle();
    t_status();
    t_rw_regs();
    t_npc();
    t_tick();
    t_priv();
    t_user();
    t_shadow_and_high();
    t_prevpc();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule